// File: doc/BRIEF.md
# Transaction-Layer Packet Digest Engine

This block adds and verifies an optional 32-bit end-to-end CRC digest on transaction-layer packets. It sits on the packet path between the application side and the rest of the transaction layer, with one 32-bit doubleword stream in each direction. Each stream carries a valid, a start-of-packet marker and an end-of-packet marker with every doubleword.

On the transmit side, the block reads a digest-request flag in the first header doubleword. When the flag is set, it appends a doubleword that holds the complemented CRC of the whole packet. The output is then one beat longer, so the input ready drops for one cycle while that beat goes out.

On the receive side, the block recomputes the CRC of a flagged packet and compares it with the trailing doubleword. It drops that doubleword from the output and pulses an error flag with the last beat it delivers. A bypass input turns off generation, checking and stripping, and packets then pass through unchanged in both directions.

Top module: `tlp_digest_engine`

## Requirements
- R1: A transmit packet whose first doubleword has bit 15 (the digest flag) clear leaves the transmit output with the same doublewords and the same start and end markers, one cycle after each beat is accepted, and the input ready stays high.
- R2: With bypass low and bit 15 of the first doubleword set, the transmit output carries the packet's doublewords unchanged. The end marker is cleared on the last of them. One extra doubleword with only the end marker set follows. Its value is the bitwise complement of a CRC-32 over all the packet's doublewords, using polynomial 0x04C11DB7, a register seeded with all ones, and bits 31 down to 0 of each doubleword fed most significant bit first.
- R3: After the transmit side accepts the last beat of a packet that gets a digest, the input ready is low for exactly one cycle and then returns high.
- R4: With bypass high, a transmit packet with the digest flag set goes out unchanged and gets no appended doubleword.
- R5: With bypass low, a receive packet of two or more doublewords with the digest flag set appears on the receive output without its final doubleword, and the end marker is on the doubleword before it.
- R6: For such a packet, the error output pulses high for one cycle together with the output end-of-packet beat exactly when the final doubleword differs from the complemented CRC (as defined in R2) of the doublewords before it. When the two match, the error output stays low.
- R7: With bypass high, a receive packet with the digest flag set passes unchanged, trailing doubleword included, and the error output stays low even when that doubleword is wrong.
- R8: A receive packet with the digest flag clear passes unchanged and is not checked.
- R9: A single-doubleword receive packet (start and end on the same beat) passes unchanged even when its digest flag is set.
- R10: After reset, both output valids and the error output are low and the transmit input ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bypass_en | input | 1 | Turns off digest generation, checking and stripping |
| tx_in_valid | input | 1 | Transmit input beat valid |
| tx_in_sop | input | 1 | Transmit input start of packet |
| tx_in_eop | input | 1 | Transmit input end of packet |
| tx_in_data | input | 32 | Transmit input doubleword |
| tx_in_ready | output | 1 | Transmit input can accept a beat |
| tx_out_valid | output | 1 | Transmit output beat valid |
| tx_out_sop | output | 1 | Transmit output start of packet |
| tx_out_eop | output | 1 | Transmit output end of packet |
| tx_out_data | output | 32 | Transmit output doubleword |
| rx_in_valid | input | 1 | Receive input beat valid |
| rx_in_sop | input | 1 | Receive input start of packet |
| rx_in_eop | input | 1 | Receive input end of packet |
| rx_in_data | input | 32 | Receive input doubleword |
| rx_out_valid | output | 1 | Receive output beat valid |
| rx_out_sop | output | 1 | Receive output start of packet |
| rx_out_eop | output | 1 | Receive output end of packet |
| rx_out_data | output | 32 | Receive output doubleword |
| rx_crc_err | output | 1 | One-cycle digest mismatch pulse on the output end beat |

## Verification
Transmit packets are sent with the flag clear, with the flag set at lengths of one and three doublewords, and with the flag set under bypass. This separates a plain pass-through from an append, checks that the CRC runs over the header doubleword, and shows that bypass suppresses the append. On the receive side, a good digest and a corrupted digest tell a silent strip apart from an error pulse. A wrong digest under bypass shows that both checking and stripping are off. A header-plus-digest packet and a single-doubleword packet cover the shortest strip and the case where no strip is allowed. Back-to-back transmit packets confirm that the one-cycle ready drop does not lose or reorder beats.

// File: rtl/tlp_digest_pkg.sv
package tlp_digest_pkg;

    localparam int DW_W = 32;
    localparam logic [DW_W-1:0] CRC_POLY = 32'h04C1_1DB7;
    localparam logic [DW_W-1:0] CRC_SEED = 32'hFFFF_FFFF;

    typedef struct packed {
        logic            sop;
        logic            eop;
        logic [DW_W-1:0] data;
    } dw_beat_t;

    // Advance the CRC register by one doubleword, most significant bit first.
    function automatic logic [DW_W-1:0] crc_step(input logic [DW_W-1:0] crc_in,
                                                  input logic [DW_W-1:0] dw);
        logic [DW_W-1:0] c;
        logic            fb;
        c = crc_in;
        for (int i = DW_W - 1; i >= 0; i--) begin
            fb = c[DW_W-1] ^ dw[i];
            c  = {c[DW_W-2:0], 1'b0};
            if (fb) c = c ^ CRC_POLY;
        end
        return c;
    endfunction

endpackage

// File: rtl/tlp_digest_tx.sv
module tlp_digest_tx
    import tlp_digest_pkg::*;
#(
    parameter int FLAG_POS = 15
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            bypass_en,
    input  logic            in_valid,
    input  logic            in_sop,
    input  logic            in_eop,
    input  logic [DW_W-1:0] in_data,
    output logic            in_ready,
    output logic            out_valid,
    output dw_beat_t        out_beat
);

    logic            pend_q;
    logic [DW_W-1:0] dig_q;
    logic [DW_W-1:0] crc_q;
    logic            flag_q;

    logic            accept;
    logic            flag_now;
    logic [DW_W-1:0] crc_nx;
    logic            insert;

    assign in_ready = !pend_q;
    assign accept   = in_valid && !pend_q;
    assign flag_now = in_sop ? in_data[FLAG_POS] : flag_q;
    assign crc_nx   = crc_step(in_sop ? CRC_SEED : crc_q, in_data);
    assign insert   = accept && in_eop && flag_now && !bypass_en;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q    <= 1'b0;
            dig_q     <= '0;
            crc_q     <= CRC_SEED;
            flag_q    <= 1'b0;
            out_valid <= 1'b0;
            out_beat  <= '0;
        end else if (pend_q) begin
            out_valid     <= 1'b1;
            out_beat.sop  <= 1'b0;
            out_beat.eop  <= 1'b1;
            out_beat.data <= dig_q;
            pend_q        <= 1'b0;
        end else if (accept) begin
            out_valid     <= 1'b1;
            out_beat.sop  <= in_sop;
            out_beat.eop  <= in_eop && !insert;
            out_beat.data <= in_data;
            crc_q         <= crc_nx;
            flag_q        <= flag_now;
            if (insert) begin
                pend_q <= 1'b1;
                dig_q  <= ~crc_nx;
            end
        end else begin
            out_valid <= 1'b0;
        end
    end

endmodule

// File: rtl/tlp_digest_rx.sv
module tlp_digest_rx
    import tlp_digest_pkg::*;
#(
    parameter int FLAG_POS = 15
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            bypass_en,
    input  logic            in_valid,
    input  logic            in_sop,
    input  logic            in_eop,
    input  logic [DW_W-1:0] in_data,
    output logic            out_valid,
    output dw_beat_t        out_beat,
    output logic            crc_err
);

    logic            strip_q;
    logic            hold_vld_q;
    dw_beat_t        hold_q;
    logic [DW_W-1:0] crc_q;

    logic            strip_now;
    logic [DW_W-1:0] crc_base;

    assign strip_now = in_sop ? (in_data[FLAG_POS] && !bypass_en && !in_eop) : strip_q;
    assign crc_base  = in_sop ? CRC_SEED : crc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            strip_q    <= 1'b0;
            hold_vld_q <= 1'b0;
            hold_q     <= '0;
            crc_q      <= CRC_SEED;
            out_valid  <= 1'b0;
            out_beat   <= '0;
            crc_err    <= 1'b0;
        end else begin
            out_valid <= 1'b0;
            crc_err   <= 1'b0;
            if (in_valid) begin
                if (in_sop) strip_q <= strip_now;
                if (strip_now) begin
                    if (in_eop) begin
                        out_valid     <= 1'b1;
                        out_beat.sop  <= hold_q.sop;
                        out_beat.eop  <= 1'b1;
                        out_beat.data <= hold_q.data;
                        hold_vld_q    <= 1'b0;
                        crc_err       <= (in_data != ~crc_q) && !bypass_en;
                    end else begin
                        if (hold_vld_q) begin
                            out_valid     <= 1'b1;
                            out_beat.sop  <= hold_q.sop;
                            out_beat.eop  <= 1'b0;
                            out_beat.data <= hold_q.data;
                        end
                        hold_vld_q  <= 1'b1;
                        hold_q.sop  <= in_sop;
                        hold_q.eop  <= 1'b0;
                        hold_q.data <= in_data;
                        crc_q       <= crc_step(crc_base, in_data);
                    end
                end else begin
                    out_valid     <= 1'b1;
                    out_beat.sop  <= in_sop;
                    out_beat.eop  <= in_eop;
                    out_beat.data <= in_data;
                end
            end
        end
    end

endmodule

// File: rtl/tlp_digest_engine.sv
module tlp_digest_engine
    import tlp_digest_pkg::*;
#(
    parameter int FLAG_POS = 15
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            bypass_en,
    input  logic            tx_in_valid,
    input  logic            tx_in_sop,
    input  logic            tx_in_eop,
    input  logic [DW_W-1:0] tx_in_data,
    output logic            tx_in_ready,
    output logic            tx_out_valid,
    output logic            tx_out_sop,
    output logic            tx_out_eop,
    output logic [DW_W-1:0] tx_out_data,
    input  logic            rx_in_valid,
    input  logic            rx_in_sop,
    input  logic            rx_in_eop,
    input  logic [DW_W-1:0] rx_in_data,
    output logic            rx_out_valid,
    output logic            rx_out_sop,
    output logic            rx_out_eop,
    output logic [DW_W-1:0] rx_out_data,
    output logic            rx_crc_err
);

    dw_beat_t tx_beat;
    dw_beat_t rx_beat;

    tlp_digest_tx #(.FLAG_POS(FLAG_POS)) tx_i (
        .clk       (clk),
        .rst       (rst),
        .bypass_en (bypass_en),
        .in_valid  (tx_in_valid),
        .in_sop    (tx_in_sop),
        .in_eop    (tx_in_eop),
        .in_data   (tx_in_data),
        .in_ready  (tx_in_ready),
        .out_valid (tx_out_valid),
        .out_beat  (tx_beat)
    );

    tlp_digest_rx #(.FLAG_POS(FLAG_POS)) rx_i (
        .clk       (clk),
        .rst       (rst),
        .bypass_en (bypass_en),
        .in_valid  (rx_in_valid),
        .in_sop    (rx_in_sop),
        .in_eop    (rx_in_eop),
        .in_data   (rx_in_data),
        .out_valid (rx_out_valid),
        .out_beat  (rx_beat),
        .crc_err   (rx_crc_err)
    );

    assign tx_out_sop  = tx_beat.sop;
    assign tx_out_eop  = tx_beat.eop;
    assign tx_out_data = tx_beat.data;
    assign rx_out_sop  = rx_beat.sop;
    assign rx_out_eop  = rx_beat.eop;
    assign rx_out_data = rx_beat.data;

endmodule

// File: rtl/tlp_digest_engine_chk.sv
module tlp_digest_engine_chk (
    input logic clk,
    input logic rst,
    input logic bypass_en,
    input logic tx_in_ready,
    input logic tx_out_valid,
    input logic tx_out_eop,
    input logic tx_out_sop,
    input logic rx_out_valid,
    input logic rx_out_eop,
    input logic rx_crc_err
);

    // R3
    ready_gap_chk: assert property (@(posedge clk) disable iff (rst)
        !tx_in_ready |=> tx_in_ready);

    // R2
    digest_prev_chk: assert property (@(posedge clk) disable iff (rst)
        !tx_in_ready |-> (tx_out_valid && !tx_out_eop));

    // R2
    digest_beat_chk: assert property (@(posedge clk) disable iff (rst)
        !tx_in_ready |=> (tx_out_valid && tx_out_eop && !tx_out_sop));

    // R6
    err_on_end_chk: assert property (@(posedge clk) disable iff (rst)
        rx_crc_err |-> (rx_out_valid && rx_out_eop));

    // R6
    err_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rx_crc_err |=> !rx_crc_err);

    // R7
    bypass_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        $past(bypass_en) |-> !rx_crc_err);

endmodule

bind tlp_digest_engine tlp_digest_engine_chk chk_i (
    .clk          (clk),
    .rst          (rst),
    .bypass_en    (bypass_en),
    .tx_in_ready  (tx_in_ready),
    .tx_out_valid (tx_out_valid),
    .tx_out_eop   (tx_out_eop),
    .tx_out_sop   (tx_out_sop),
    .rx_out_valid (rx_out_valid),
    .rx_out_eop   (rx_out_eop),
    .rx_crc_err   (rx_crc_err)
);

// File: tb/tlp_digest_engine_tb_top.sv
module tlp_digest_engine_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bypass_en = 1'b0;
    logic        tx_in_valid = 1'b0, tx_in_sop = 1'b0, tx_in_eop = 1'b0;
    logic [31:0] tx_in_data = '0;
    logic        tx_in_ready, tx_out_valid, tx_out_sop, tx_out_eop;
    logic [31:0] tx_out_data;
    logic        rx_in_valid = 1'b0, rx_in_sop = 1'b0, rx_in_eop = 1'b0;
    logic [31:0] rx_in_data = '0;
    logic        rx_out_valid, rx_out_sop, rx_out_eop, rx_crc_err;
    logic [31:0] rx_out_data;

    always #5 clk = ~clk;

    tlp_digest_engine dut_i (
        .clk(clk), .rst(rst), .bypass_en(bypass_en),
        .tx_in_valid(tx_in_valid), .tx_in_sop(tx_in_sop), .tx_in_eop(tx_in_eop),
        .tx_in_data(tx_in_data), .tx_in_ready(tx_in_ready),
        .tx_out_valid(tx_out_valid), .tx_out_sop(tx_out_sop), .tx_out_eop(tx_out_eop),
        .tx_out_data(tx_out_data),
        .rx_in_valid(rx_in_valid), .rx_in_sop(rx_in_sop), .rx_in_eop(rx_in_eop),
        .rx_in_data(rx_in_data),
        .rx_out_valid(rx_out_valid), .rx_out_sop(rx_out_sop), .rx_out_eop(rx_out_eop),
        .rx_out_data(rx_out_data), .rx_crc_err(rx_crc_err)
    );

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;

    logic [31:0] pkt[$];
    logic [33:0] tx_exp[$];
    string       tx_tag[$];
    logic [34:0] rx_exp[$];
    string       rx_tag[$];

    // Reference CRC: remainder of (crc xor dw) * x^32 divided by the generator.
    function automatic logic [31:0] ref_crc(input logic [31:0] c, input logic [31:0] dw);
        logic [63:0] v;
        v = {c ^ dw, 32'h0};
        for (int i = 63; i >= 32; i--)
            if (v[i]) v = v ^ ({32'h1, 32'h04C1_1DB7} << (i - 32));
        return v[31:0];
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: %s actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Monitor: compare outputs with the model's expected stream on every clock.
    always @(negedge clk) begin
        if (!rst) begin
            cycles++;
            if (tx_out_valid) begin
                if (tx_exp.size() == 0)
                    check(0, "R1", "unexpected tx beat", {30'h0, tx_out_sop, tx_out_eop, tx_out_data}, 0);
                else begin
                    logic [33:0] e;
                    string t;
                    e = tx_exp.pop_front();
                    t = tx_tag.pop_front();
                    check({tx_out_sop, tx_out_eop, tx_out_data} === e, t, "tx beat",
                          {30'h0, tx_out_sop, tx_out_eop, tx_out_data}, {30'h0, e});
                end
            end
            if (rx_out_valid) begin
                if (rx_exp.size() == 0)
                    check(0, "R5", "unexpected rx beat", {29'h0, rx_crc_err, rx_out_sop, rx_out_eop, rx_out_data}, 0);
                else begin
                    logic [34:0] e;
                    string t;
                    e = rx_exp.pop_front();
                    t = rx_tag.pop_front();
                    check({rx_crc_err, rx_out_sop, rx_out_eop, rx_out_data} === e, t, "rx beat",
                          {29'h0, rx_crc_err, rx_out_sop, rx_out_eop, rx_out_data}, {29'h0, e});
                end
            end else if (rx_crc_err) begin
                check(0, "R6", "error without output beat", 1, 0);
            end
        end
    end

    task automatic tx_send(input string req);
        logic [31:0] crc;
        bit flag, dig;
        int n;
        n    = pkt.size();
        crc  = 32'hFFFF_FFFF;
        flag = pkt[0][15];
        dig  = flag && !bypass_en;
        for (int i = 0; i < n; i++) begin
            crc = ref_crc(crc, pkt[i]);
            tx_exp.push_back({i == 0, (i == n - 1) && !dig, pkt[i]});
            tx_tag.push_back(req);
        end
        if (dig) begin
            tx_exp.push_back({1'b0, 1'b1, ~crc});
            tx_tag.push_back("R2");
        end
        for (int i = 0; i < n; i++) begin
            tx_in_valid = 1'b1;
            tx_in_sop   = (i == 0);
            tx_in_eop   = (i == n - 1);
            tx_in_data  = pkt[i];
            while (!tx_in_ready) @(negedge clk);
            @(negedge clk);
        end
        tx_in_valid = 1'b0;
        tx_in_sop   = 1'b0;
        tx_in_eop   = 1'b0;
        if (dig) begin
            check(tx_in_ready == 1'b0, "R3", "ready after digest end", {63'h0, tx_in_ready}, 0);
            @(negedge clk);
            check(tx_in_ready == 1'b1, "R3", "ready restored", {63'h0, tx_in_ready}, 1);
        end else begin
            check(tx_in_ready == 1'b1, req, "ready without digest", {63'h0, tx_in_ready}, 1);
        end
    endtask

    task automatic rx_send(input bit add_dig, input bit bad, input string req);
        logic [31:0] crc;
        bit strip;
        int n;
        crc = 32'hFFFF_FFFF;
        for (int i = 0; i < pkt.size(); i++) crc = ref_crc(crc, pkt[i]);
        if (add_dig) pkt.push_back(~crc ^ (bad ? 32'h0000_0100 : 32'h0));
        n     = pkt.size();
        strip = pkt[0][15] && !bypass_en && (n > 1);
        for (int i = 0; i < (strip ? n - 1 : n); i++) begin
            bit last;
            last = strip ? (i == n - 2) : (i == n - 1);
            rx_exp.push_back({strip && last && bad, i == 0, last, pkt[i]});
            rx_tag.push_back(req);
        end
        for (int i = 0; i < n; i++) begin
            rx_in_valid = 1'b1;
            rx_in_sop   = (i == 0);
            rx_in_eop   = (i == n - 1);
            rx_in_data  = pkt[i];
            @(negedge clk);
        end
        rx_in_valid = 1'b0;
        rx_in_sop   = 1'b0;
        rx_in_eop   = 1'b0;
    endtask

    task automatic drain(input string req);
        repeat (4) @(negedge clk);
        check(tx_exp.size() == 0, req, "tx beats missing", tx_exp.size(), 0);
        check(rx_exp.size() == 0, req, "rx beats missing", rx_exp.size(), 0);
    endtask

    initial begin : watchdog
        wait (cycles > 20000);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: cycles %0d expected below %0d", cycles, 20000);
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        check(tx_out_valid == 0 && rx_out_valid == 0, "R10", "valids after reset",
              {62'h0, tx_out_valid, rx_out_valid}, 0);
        check(tx_in_ready == 1 && rx_crc_err == 0, "R10", "ready/err after reset",
              {62'h0, tx_in_ready, rx_crc_err}, 2);

        // R1 no flag
        pkt = '{32'h4000_0004, 32'h1111_2222, 32'h3333_4444, 32'h5555_6666};
        tx_send("R1");
        drain("R1");
        // R2 flagged, three doublewords
        pkt = '{32'h4000_8002, 32'hDEAD_BEEF, 32'h0BAD_F00D};
        tx_send("R2");
        drain("R2");
        // R2 flagged, single doubleword
        pkt = '{32'h0000_8000};
        tx_send("R2");
        drain("R2");
        // R4 bypass
        bypass_en = 1'b1;
        pkt = '{32'h4000_8002, 32'hCAFE_0001, 32'hCAFE_0002};
        tx_send("R4");
        drain("R4");
        bypass_en = 1'b0;
        // R1/R2 back to back
        pkt = '{32'h4400_8001, 32'h1234_5678};
        tx_send("R2");
        pkt = '{32'h4400_0001, 32'h8765_4321};
        tx_send("R1");
        drain("R1");

        // R5/R6 good digest
        pkt = '{32'h4A00_8003, 32'hA0A0_A0A0, 32'hB1B1_B1B1, 32'hC2C2_C2C2};
        rx_send(1, 0, "R5");
        drain("R5");
        // R6 bad digest
        pkt = '{32'h4A00_8002, 32'h0102_0304, 32'h0506_0708};
        rx_send(1, 1, "R6");
        drain("R6");
        // R7 bypass, bad digest kept
        bypass_en = 1'b1;
        pkt = '{32'h4A00_8002, 32'h0102_0304, 32'h0506_0708};
        rx_send(1, 1, "R7");
        drain("R7");
        bypass_en = 1'b0;
        // R8 flag clear
        pkt = '{32'h4A00_0002, 32'h7777_0000, 32'h0000_7777};
        rx_send(0, 0, "R8");
        drain("R8");
        // R9 single beat with flag
        pkt = '{32'h0000_8000};
        rx_send(0, 0, "R9");
        drain("R9");
        // R5/R6 header plus digest, bad then good back to back
        pkt = '{32'h0000_8000};
        rx_send(1, 1, "R6");
        pkt = '{32'h0000_8000};
        rx_send(1, 0, "R5");
        drain("R5");

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

endmodule